// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between a CPU bus and a game cartridge's memories. The CPU cannot write into the 32 KiB read-only area at 0x0000–0x7FFF. Any write there is therefore taken as a control-register write, picked by address bits [15:13]. From these writes the block keeps four values: a 5-bit low ROM bank field, a 2-bit secondary field, a banking-mode bit and an external-RAM enable.

For the CPU address currently on the bus, the block forms two physical addresses. One is a 21-bit ROM address: the fixed 16 KiB window at 0x0000–0x3FFF always maps to bank 0, and the switchable window at 0x4000–0x7FFF maps to the selected bank. That bank is wrapped to the ROM size set on a 3-bit input. The other is a 15-bit external-RAM address for the 8 KiB window at 0xA000–0xBFFF.

The enable flag gates the external RAM. While RAM is disabled, the CPU reads 0xFF and the write strobe to the RAM array stays low. The ROM and RAM arrays themselves lie outside the block.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the ROM bank is 1, the RAM bank is 0, the mode is 0 and external RAM is disabled.
- R2: A write to 0x0000–0x1FFF with data 0x0A enables external RAM. Data 0x00 disables it. Any other data leaves the enable unchanged.
- R3: A write to 0x2000–0x3FFF loads data bits [4:0] into ROM bank bits [4:0], and a value of 0 in those bits becomes 1. ROM bank bits [6:5] are kept.
- R4: A write to 0x4000–0x5FFF loads data bits [1:0] into ROM bank bits [6:5] when mode is 0, or into the RAM bank when mode is 1. The other field is kept.
- R5: A write to 0x6000–0x7FFF sets mode to data bit 0. Mode 1 clears ROM bank bits [6:5]. Mode 0 clears the RAM bank.
- R6: `rom_size_sel` = s sets a ROM size of 32 KiB << s, which is 2 << s banks; values above 6 act as 6. The bank used for mapping is the selected bank ANDed with (bank count − 1).
- R7: For an address below 0x4000, `rom_addr` is address bits [13:0] with zeros above them. For 0x4000–0x7FFF, `rom_addr` is the wrapped bank × 16384 + address bits [13:0].
- R8: `ram_addr` is the RAM bank × 8192 + address bits [12:0].
- R9: For an address in 0xA000–0xBFFF, `ram_rdata_o` is `ram_rdata_i` while RAM is enabled and 0xFF while it is disabled. `ram_we` is high only for a CPU write in that range while RAM is enabled.
- R10: A CPU write at 0x8000 or above changes no bank, mode or enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address, for reads and writes |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_wdata | input | 8 | CPU write data |
| rom_size_sel | input | 3 | ROM size code: 32 KiB << value |
| ram_rdata_i | input | 8 | Read data from the external RAM array |
| rom_addr | output | 21 | Physical ROM byte address for cpu_addr |
| ram_addr | output | 15 | Physical external-RAM byte address for cpu_addr |
| ram_we | output | 1 | Gated write strobe to the external RAM array |
| ram_rdata_o | output | 8 | External-RAM read data returned to the CPU |
| ram_enabled | output | 1 | External RAM enable flag |

## Verification
The hardest state to reach is a bank value that is only visible after a sequence of writes. A high ROM bank combined with a small ROM size needs writes to both bank fields in mode 0, then a change of the size code. A mode switch taken while the other field is non-zero is the only way to see it clear that field. The stimulus mixes directed sequences for these cases with random writes spread across the four control regions and the RAM window. The random data is biased toward 0x00, 0x0A and values whose low bits are zero, and the size code is changed now and then. After each write, a bench model predicts the ROM and RAM mapping at probe addresses in both ROM windows and the RAM window.

// File: rtl/cart_bank_pkg.sv
// Package: shared widths, control-region codes and the bank state record
// used by every module of the cartridge bank controller.
package cart_bank_pkg;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int LO_W       = 5;
    localparam int HI_W       = 2;
    localparam int BANK_W     = LO_W + HI_W;
    localparam int ROM_OFS_W  = 14;
    localparam int RAM_OFS_W  = 13;
    localparam int ROM_ADDR_W = BANK_W + ROM_OFS_W;
    localparam int RAM_ADDR_W = HI_W + RAM_OFS_W;
    localparam int SEL_W      = 3;
    localparam int REGION_W   = 3;

    // Control regions picked by address bits [15:13]
    typedef enum logic [REGION_W-1:0] {
        RG_RAM_EN  = 3'd0,
        RG_BANK_LO = 3'd1,
        RG_BANK_HI = 3'd2,
        RG_MODE    = 3'd3
    } region_e;

    localparam logic [DATA_W-1:0] RAM_ON_CODE  = 8'h0A;
    localparam logic [DATA_W-1:0] RAM_OFF_CODE = 8'h00;
    localparam logic [DATA_W-1:0] OPEN_BUS     = 8'hFF;

    typedef struct packed {
        logic [LO_W-1:0] rom_lo;
        logic [HI_W-1:0] rom_hi;
        logic [HI_W-1:0] ram_bank;
        logic            mode;
        logic            ram_en;
    } bank_state_t;
endpackage

// File: rtl/cart_bank_regs.sv
// Control-register file. A CPU write below 0x8000 updates the bank fields,
// the mode and the RAM enable, chosen by address bits [15:13].
// Assumes cpu_wr lasts one cycle for each write.
module cart_bank_regs
    import cart_bank_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [REGION_W-1:0] region,
    input  logic [DATA_W-1:0]   wdata,
    output bank_state_t         st
);
    logic [LO_W-1:0] lo_next;

    // Low bank field with the zero-to-one substitution
    always_comb begin
        lo_next = wdata[LO_W-1:0];
        if (lo_next == '0) lo_next = LO_W'(1);
    end

    // Register update on control writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st.rom_lo   <= LO_W'(1);
            st.rom_hi   <= '0;
            st.ram_bank <= '0;
            st.mode     <= 1'b0;
            st.ram_en   <= 1'b0;
        end else if (wr) begin
            case (region)
                RG_RAM_EN: begin
                    if (wdata == RAM_ON_CODE)       st.ram_en <= 1'b1;
                    else if (wdata == RAM_OFF_CODE) st.ram_en <= 1'b0;
                end
                RG_BANK_LO: st.rom_lo <= lo_next;
                RG_BANK_HI: begin
                    if (st.mode) st.ram_bank <= wdata[HI_W-1:0];
                    else         st.rom_hi   <= wdata[HI_W-1:0];
                end
                RG_MODE: begin
                    st.mode <= wdata[0];
                    if (wdata[0]) st.rom_hi   <= '0;
                    else          st.ram_bank <= '0;
                end
                default: ;
            endcase
        end
    end

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (st.rom_lo == LO_W'(1) && st.rom_hi == '0 &&
                          st.ram_bank == '0 && !st.mode && !st.ram_en));

    a_r2_other_value_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && region == RG_RAM_EN && wdata != RAM_ON_CODE && wdata != RAM_OFF_CODE)
        |=> $stable(st.ram_en));

    a_r3_low_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        st.rom_lo != '0);

    a_r5_mode1_clears_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && region == RG_MODE && wdata[0]) |=> (st.rom_hi == '0 && st.mode));

    a_r5_mode0_clears_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && region == RG_MODE && !wdata[0]) |=> (st.ram_bank == '0 && !st.mode));

    a_r10_high_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && region[REGION_W-1]) |=> $stable(st));
endmodule

// File: rtl/cart_rom_map.sv
// ROM address mapper. The fixed window maps to bank 0. The switchable window
// maps to the selected bank ANDed with a mask of (2 << size_sel) - 1.
// Assumes size codes above the largest supported size act as the largest.
module cart_rom_map
    import cart_bank_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  bank_state_t           st,
    input  logic [SEL_W-1:0]      size_sel,
    input  logic [ROM_OFS_W:0]    addr,
    output logic [ROM_ADDR_W-1:0] rom_addr
);
    localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(BANK_W - 1);

    logic [SEL_W-1:0]  sel_sat;
    logic [BANK_W-1:0] mask;
    logic [BANK_W-1:0] bank_sel;
    logic [BANK_W-1:0] bank_eff;

    // Clamp the size code to the largest supported size
    always_comb sel_sat = (size_sel > MAX_SEL) ? MAX_SEL : size_sel;

    // One mask bit for each bank-number bit the configured size needs
    for (genvar i = 0; i < BANK_W; i++) begin : g_mask
        assign mask[i] = (SEL_W'(i) <= sel_sat);
    end

    // Full selected bank, wrapped and applied to the addressed window
    always_comb begin
        bank_sel = {st.rom_hi, st.rom_lo};
        bank_eff = addr[ROM_OFS_W] ? (bank_sel & mask) : '0;
        rom_addr = {bank_eff, addr[ROM_OFS_W-1:0]};
    end

    a_r6_within_rom_size: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_addr >> (ROM_OFS_W + 1 + int'(sel_sat))) == '0);

    a_r7_fixed_window_bank0: assert property (@(posedge clk) disable iff (!rst_n)
        !addr[ROM_OFS_W] |-> (rom_addr[ROM_ADDR_W-1:ROM_OFS_W] == '0));
endmodule

// File: rtl/cart_ram_gate.sv
// External-RAM window: forms the banked RAM address, gates the write strobe
// with the enable and returns open-bus data while RAM is disabled.
// Assumes the window is 0xA000-0xBFFF (address bits [15:13] = 3'b101).
module cart_ram_gate
    import cart_bank_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  bank_state_t           st,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr,
    input  logic [DATA_W-1:0]     rdata_i,
    output logic [RAM_ADDR_W-1:0] ram_addr,
    output logic                  ram_we,
    output logic [DATA_W-1:0]     rdata_o
);
    localparam logic [REGION_W-1:0] RAM_WINDOW = 3'b101;

    logic in_window;

    // Window decode and banked address
    always_comb begin
        in_window = (addr[ADDR_W-1:RAM_OFS_W] == RAM_WINDOW);
        ram_addr  = {st.ram_bank, addr[RAM_OFS_W-1:0]};
    end

    // Enable gating of the write strobe and read data
    always_comb begin
        ram_we  = wr && in_window && st.ram_en;
        rdata_o = st.ram_en ? rdata_i : OPEN_BUS;
    end

    a_r9_no_write_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !st.ram_en |-> !ram_we);

    a_r8_bank_in_address: assert property (@(posedge clk) disable iff (!rst_n)
        ram_addr[RAM_ADDR_W-1:RAM_OFS_W] == st.ram_bank);
endmodule

// File: rtl/cart_bank_ctrl.sv
// Top of the cartridge bank controller. CPU writes below 0x8000 are decoded
// as control writes. Physical ROM and RAM addresses for cpu_addr are formed
// combinationally from the registered bank state.
module cart_bank_ctrl
    import cart_bank_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic                  cpu_wr,
    input  logic [DATA_W-1:0]     cpu_wdata,
    input  logic [SEL_W-1:0]      rom_size_sel,
    input  logic [DATA_W-1:0]     ram_rdata_i,
    output logic [ROM_ADDR_W-1:0] rom_addr,
    output logic [RAM_ADDR_W-1:0] ram_addr,
    output logic                  ram_we,
    output logic [DATA_W-1:0]     ram_rdata_o,
    output logic                  ram_enabled
);
    bank_state_t st;

    cart_bank_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cpu_wr),
        .region (cpu_addr[ADDR_W-1:RAM_OFS_W]),
        .wdata  (cpu_wdata),
        .st     (st)
    );

    cart_rom_map u_rom (
        .clk      (clk),
        .rst_n    (rst_n),
        .st       (st),
        .size_sel (rom_size_sel),
        .addr     (cpu_addr[ROM_OFS_W:0]),
        .rom_addr (rom_addr)
    );

    cart_ram_gate u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .st       (st),
        .addr     (cpu_addr),
        .wr       (cpu_wr),
        .rdata_i  (ram_rdata_i),
        .ram_addr (ram_addr),
        .ram_we   (ram_we),
        .rdata_o  (ram_rdata_o)
    );

    // Enable flag brought out for the surrounding memory system
    assign ram_enabled = st.ram_en;

    a_r9_we_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_enabled && cpu_wr));
endmodule

// File: tb/cart_bank_ctrl_tb.sv
module cart_bank_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [2:0]  rom_size_sel = 3'd6;
    logic [7:0]  ram_rdata_i = 8'h5A;
    logic [20:0] rom_addr;
    logic [14:0] ram_addr;
    logic        ram_we;
    logic [7:0]  ram_rdata_o;
    logic        ram_enabled;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench model of the bank state
    logic [4:0] m_lo;
    logic [1:0] m_hi;
    logic [1:0] m_rb;
    logic       m_mode;
    logic       m_en;

    always #2.5 clk = ~clk;

    cart_bank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .rom_size_sel(rom_size_sel),
        .ram_rdata_i(ram_rdata_i), .rom_addr(rom_addr), .ram_addr(ram_addr),
        .ram_we(ram_we), .ram_rdata_o(ram_rdata_o), .ram_enabled(ram_enabled)
    );

    function automatic logic [20:0] exp_rom(input logic [15:0] a);
        int s = (rom_size_sel > 3'd6) ? 6 : int'(rom_size_sel);
        int bank = int'({m_hi, m_lo}) & ((2 << s) - 1);
        if (a[14]) return 21'(bank * 16384 + int'(a[13:0]));
        return 21'(a[13:0]);
    endfunction

    function automatic logic [14:0] exp_ram(input logic [15:0] a);
        return 15'(int'(m_rb) * 8192 + int'(a[12:0]));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_lo = 5'd1; m_hi = '0; m_rb = '0; m_mode = 1'b0; m_en = 1'b0;
    endtask

    // One-cycle CPU write; the strobe is checked while the write is on the bus
    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        #1;
        check("R9 write strobe", 32'(ram_we), 32'(m_en && a[15:13] == 3'b101));
        @(negedge clk);
        cpu_wr = 1'b0;
        case (a[15:13])
            3'd0: if (d == 8'h0A) m_en = 1'b1; else if (d == 8'h00) m_en = 1'b0;
            3'd1: m_lo = (d[4:0] == 0) ? 5'd1 : d[4:0];
            3'd2: if (m_mode) m_rb = d[1:0]; else m_hi = d[1:0];
            3'd3: begin m_mode = d[0]; if (d[0]) m_hi = '0; else m_rb = '0; end
            default: ;
        endcase
    endtask

    // Probe the mapping of every window at the current state
    task automatic probe(input string req);
        logic [15:0] a;
        a = 16'h4000 | 16'($urandom_range(0, 16383));
        cpu_addr = a; #1;
        check({req, " R7 bank window"}, 32'(rom_addr), 32'(exp_rom(a)));
        a = 16'($urandom_range(0, 16383));
        cpu_addr = a; #1;
        check({req, " R7 fixed window"}, 32'(rom_addr), 32'(exp_rom(a)));
        a = 16'hA000 | 16'($urandom_range(0, 8191));
        ram_rdata_i = 8'($urandom);
        cpu_addr = a; #1;
        check({req, " R8 ram address"}, 32'(ram_addr), 32'(exp_ram(a)));
        check({req, " R9 read data"}, 32'(ram_rdata_o), 32'(m_en ? ram_rdata_i : 8'hFF));
        check({req, " R2 enable flag"}, 32'(ram_enabled), 32'(m_en));
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h1234_5678);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        cpu_addr = 16'h4000; #1;
        check("R1 reset rom bank", 32'(rom_addr), 32'h4000);
        cpu_addr = 16'hA000; #1;
        check("R1 reset ram bank", 32'(ram_addr), 32'h0);
        check("R1 reset ram disabled", 32'(ram_rdata_o), 32'hFF);
        check("R1 reset enable", 32'(ram_enabled), 32'h0);

        // R2: enable codes and a value that must be ignored
        wr(16'h0000, 8'h0A); probe("R2 on");
        wr(16'h1FFF, 8'h55); probe("R2 other keeps");
        wr(16'h0123, 8'h00); probe("R2 off");
        wr(16'h0000, 8'h1A); probe("R2 other keeps off");
        wr(16'h0000, 8'h0A);

        // R3: zero substitution and keeping of the upper bits
        wr(16'h4000, 8'h03); wr(16'h2000, 8'h00); probe("R3 zero to one");
        wr(16'h3FFF, 8'h20); probe("R3 0x20 to one");
        wr(16'h2100, 8'hFF); probe("R3 max low");

        // R4 and R5: mode switching clears the other field
        wr(16'h6000, 8'h01); probe("R5 mode1 clears hi");
        wr(16'h4000, 8'h02); probe("R4 mode1 ram bank");
        wr(16'h6000, 8'h00); probe("R5 mode0 clears ram bank");
        wr(16'h5FFF, 8'h03); probe("R4 mode0 upper rom bits");

        // R6: wrapping, including size codes above the maximum
        for (int s = 0; s < 8; s++) begin
            rom_size_sel = 3'(s);
            probe("R6 wrap");
        end
        rom_size_sel = 3'd0;
        wr(16'h2000, 8'h02); probe("R6 wrap to bank 0");

        // R10: writes above the ROM area are ignored
        wr(16'h8000, 8'h0A); wr(16'hA000, 8'h00); wr(16'hC000, 8'h01);
        wr(16'hE000, 8'h00); probe("R10 high writes");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            a = 16'($urandom);
            if ($urandom_range(0, 3) != 0) a[15] = 1'b0;
            case ($urandom_range(0, 4))
                0: d = 8'h0A;
                1: d = 8'h00;
                2: d = 8'($urandom) & 8'hE0;
                default: d = 8'($urandom);
            endcase
            if ($urandom_range(0, 15) == 0) rom_size_sel = 3'($urandom);
            wr(a, d);
            probe("random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(5 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule